// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block stands between a small group of active-low external interrupt pins and an interrupt controller. Each pin is brought into the clock domain through a two-stage synchronizer. A per-channel sensitivity bit then decides how the pin raises that channel's pending flag. With the bit set, the channel is edge-sensitive: a high-to-low transition of the synchronized pin sets the flag. With the bit clear, the channel is level-sensitive: a low pin sets the flag.

Pending flags are sticky, and they drive the request outputs one for one. Software reads and writes the block through a plain address / write-enable / read-data port, with the sensitivity register at offset 0 and the pending register at offset 4. A pending bit is acknowledged by writing a one to it. The usual sequence is to clear the flags at setup and again at the end of each service routine, so that the next event can be taken.

Top module: `extint_detect`

## Requirements
- R1: After reset, the sensitivity register reads 0 (all channels level-sensitive), the pending register reads 0, and every request output is low.
- R2: A write to offset 0 stores bits [NCH-1:0] as the sensitivity register, and a read of offset 0 returns them. Bit i = 1 makes channel i edge-sensitive and bit i = 0 makes it level-sensitive. Read bits above NCH-1 are 0.
- R3: In edge mode, bit i of the pending register (offset 4) is set by a falling edge of pin i, meaning the previous synchronized sample was high and the current one is low. The bit becomes visible after the third rising clock edge following the pin change. A pin that stays low, or a pin that rises, does not set the bit again once it has been cleared.
- R4: In level mode, a low pin i sets pending bit i within the same three-edge latency. A clear written while the pin is still low leaves the bit set.
- R5: Writing to offset 4 clears pending bit i at the next clock edge when data bit i is 1 and no set event is present. Data bits that are 0 leave their flags unchanged.
- R6: When a set event and a clear of the same bit fall in the same cycle, the set wins and the bit stays 1.
- R7: Request output i always equals pending bit i.
- R8: A read of any offset other than 0 or 4 returns 0. A write to such an offset changes neither register.
- R9: A write to the sensitivity register does not change any pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_n | input | NCH | External interrupt pins, active low, asynchronous |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe for reg_addr / reg_wdata |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_req | output | NCH | Per-channel interrupt request, active high |

## Verification
A pin change becomes visible in the pending register and on irq_req only after the third rising edge that follows it: two synchronizer stages, then the flag register. The bench therefore drives pins on a falling edge and, where the requirement is about latency, samples on the falling edge after the second rising edge (expecting no change) and again after the third (expecting the new value). Register writes take effect at the single rising edge inside the write strobe. Reads are combinational and are sampled 1 ns after the address is set on a falling edge. The set/clear collision is staged by placing the clear strobe across exactly the third rising edge after a pin drop.

// File: rtl/extint_pkg.sv
package extint_pkg;

  // register byte offsets
  localparam int unsigned SENSE_OFS   = 0;
  localparam int unsigned PENDING_OFS = 4;

  // next pending state: a set event has priority over a write-one-to-clear
  function automatic logic pend_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // falling edge: high on the previous sample, low on the current one
  function automatic logic fall_seen(input logic prev, input logic now);
    return prev & ~now;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1_q, stage2_q;

  // idle level of an active-low pin is high, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/extint_chan.sv
module extint_chan
  import extint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,      // synchronized pin, active low
  input  logic edge_mode,
  input  logic clr,
  output logic pend,
  output logic set_evt
);
  logic prev_q, pend_q, fall_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  assign fall_evt = fall_seen(prev_q, pin_s);
  assign set_evt  = edge_mode ? fall_evt : ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_next(pend_q, set_evt, clr);
  end

  assign pend = pend_q;
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pin_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    irq_req
);
  localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(SENSE_OFS);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(PENDING_OFS);

  logic [NCH-1:0] pin_s;
  logic [NCH-1:0] sense_q;
  logic [NCH-1:0] set_vec;
  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] pend_vec;
  logic           sel_sense, sel_pend;

  assign sel_sense = (reg_addr == A_SENSE);
  assign sel_pend  = (reg_addr == A_PEND);

  extint_sync #(.W(NCH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_n),
    .q_sync  (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   sense_q <= '0;
    else if (reg_wr && sel_sense) sense_q <= reg_wdata[NCH-1:0];
  end

  assign clr_vec = (reg_wr && sel_pend) ? reg_wdata[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    extint_chan u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s     (pin_s[i]),
      .edge_mode (sense_q[i]),
      .clr       (clr_vec[i]),
      .pend      (pend_vec[i]),
      .set_evt   (set_vec[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_sense)     reg_rdata[NCH-1:0] = sense_q;
    else if (sel_pend) reg_rdata[NCH-1:0] = pend_vec;
  end

  assign irq_req = pend_vec;
endmodule

// File: rtl/extint_detect_chk.sv
module extint_detect_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] sense_q,
  input logic [NCH-1:0] pin_s,
  input logic [NCH-1:0] set_vec,
  input logic [NCH-1:0] clr_vec,
  input logic [NCH-1:0] pend_vec
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R3: synchronized falling edge in edge mode sets the flag
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_q[i] && $past(pin_s[i]) && !pin_s[i]) |=> pend_vec[i]);
    // R4: low pin in level mode sets the flag
    a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_q[i] && !pin_s[i]) |=> pend_vec[i]);
    // R5: clear without a set event drops the flag
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !pend_vec[i]);
    // R6: set beats clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && set_vec[i]) |=> pend_vec[i]);
    // R5: with neither set nor clear, the flag holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(pend_vec[i]));
  end
endmodule

bind extint_detect extint_detect_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sense_q  (sense_q),
  .pin_s    (pin_s),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .pend_vec (pend_vec)
);

// File: tb/extint_detect_test.sv
module extint_detect_test;
  localparam int NCH = 4;
  localparam int AW  = 4;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH-1:0] pin_n = '1;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NCH-1:0] irq_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  extint_detect #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req)
  );

  // {sense, low pins, pending before clear, pending after clear while low}
  localparam logic [15:0] VEC [8] = '{
    16'h0111, 16'hF110, 16'h8FF7, 16'h5662,
    16'hA555, 16'h3330, 16'hCEE2, 16'h0000
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd0, d); check("R1 sense after reset", d, 0);
    rd(4'd4, d); check("R1 pending after reset", d, 0);
    check("R1 irq after reset", irq_req, 0);

    // R2 sense register write/read, upper bits masked
    wr(4'd0, 32'hFFFF_FFF5);
    rd(4'd0, d); check("R2 sense readback", d, 32'h5);
    wr(4'd0, 0);

    // vector table walk: R3 R4 R5 R7
    foreach (VEC[k]) begin
      wr(4'd0, {28'd0, VEC[k][15:12]});
      @(negedge clk); pin_n = ~VEC[k][11:8];
      idle(4);
      rd(4'd4, d); check($sformatf("R3/R4 vec%0d pending", k), d, {28'd0, VEC[k][7:4]});
      check($sformatf("R7 vec%0d irq", k), irq_req, VEC[k][7:4]);
      wr(4'd4, 32'hF);
      rd(4'd4, d); check($sformatf("R4/R5 vec%0d after clear while low", k), d, {28'd0, VEC[k][3:0]});
      @(negedge clk); pin_n = '1;
      idle(4);
      wr(4'd4, 32'hF);
      rd(4'd4, d); check($sformatf("R5 vec%0d cleared idle", k), d, 0);
    end

    // R3 latency: edge mode ch0
    wr(4'd0, 32'h1);
    @(negedge clk); pin_n[0] = 1'b0;
    @(negedge clk); @(negedge clk);          // two rising edges passed
    check("R3 not yet after two edges", irq_req, 4'h0);
    @(negedge clk);                          // third rising edge
    check("R3 set after three edges", irq_req, 4'h1);
    // R3: rising edge does not set after clear
    wr(4'd4, 32'h1);
    @(negedge clk); pin_n[0] = 1'b1;
    idle(5);
    rd(4'd4, d); check("R3 rise does not set", d, 0);

    // R5: writing zeros leaves flags
    @(negedge clk); pin_n[0] = 1'b0;
    idle(4);
    wr(4'd4, 32'hE);
    rd(4'd4, d); check("R5 zero bits leave flag", d, 32'h1);
    // R9: sense write keeps flags
    wr(4'd0, 32'h3);
    rd(4'd4, d); check("R9 sense write keeps pending", d, 32'h1);
    wr(4'd4, 32'h1);
    @(negedge clk); pin_n[0] = 1'b1;
    idle(4);

    // R6: collision of fall event and clear on channel 0
    @(negedge clk); pin_n[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    reg_addr = 4'd4; reg_wdata = 32'h1; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(4'd4, d); check("R6 set wins over clear", d, 32'h1);
    @(negedge clk); pin_n[0] = 1'b1;
    idle(4);
    wr(4'd4, 32'hF);

    // R8 unmapped offsets
    wr(4'd8, 32'hF);
    rd(4'd8, d); check("R8 unmapped read", d, 0);
    rd(4'd0, d); check("R8 unmapped write ignored", d, 32'h3);
    rd(4'd4, d); check("R8 pending untouched", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule